// File: doc/BRIEF.md
# Fast A20 Gate and Warm Reset Controller

This block gives a processor a fast path to the legacy A20 address gate and to a warm CPU reset, so it need not wait on a slow keyboard controller. It watches every I/O write. A write to port 92h sets the A20 enable directly and can start a warm reset. When the snoop function is on, the block also follows the keyboard-controller command sequences on ports 64h and 60h and acts on them. The keyboard controller still receives those writes.

An 8-bit control word enables each path on its own, and is written through `cfg_wr`/`cfg_wdata`. That word has three functions: snooping, port 92h decode, and holding the A20 mask deasserted for the whole of a warm reset. The A20 mask output is active low. The warm reset output is a pulse of `RST_CYCLES` clocks. A read of port 92h returns the present gate state.

Top module: `fast_a20_rst`

## Requirements
- R1: After reset the control word is 98h, so snooping (bit 7), the A20-high override (bit 4) and port 92h decode (bit 3) are all on. A20 is disabled (`a20m_n` = 0), `warm_rst` is 0 and no snoop command is pending.
- R2: With decode on, a write to port 92h loads the A20 enable from data bit 1. Outside a warm reset with override, `a20m_n` equals that enable from the next cycle on.
- R3: With decode off (control bit 3 = 0), writes to port 92h change neither A20 nor reset. Reads of port 92h are not claimed (`p92_claim` = 0) and return 0.
- R4: With decode on, a port 92h write whose bit 0 is 1 starts a warm reset when the previously written bit 0 was 0. The pulse is `RST_CYCLES` clocks long. Writing bit 0 = 1 again while it is already 1 starts nothing.
- R5: A read of port 92h with decode on asserts `p92_claim` in the same cycle. `p92_rdata` then holds the A20 enable in bit 1 and 0 in all other bits, bit 0 included.
- R6: With snooping on, a D1h write to port 64h arms a pending command. The next write to port 60h sets A20 from data bit 1 and clears the pending command. Any other port 64h write cancels the pending command.
- R7: With snooping on, a FEh write to port 64h starts a warm reset of `RST_CYCLES` clocks.
- R8: With snooping off (control bit 7 = 0), writes to ports 64h and 60h change neither A20 nor reset, and any pending command is dropped.
- R9: While `warm_rst` is 1 and control bit 4 is 1, `a20m_n` is 1 whatever the A20 enable is. With bit 4 = 0, `a20m_n` follows the A20 enable during the pulse.
- R10: A control write takes effect from the next cycle. An I/O write in the same cycle is judged by the old control value.
- R11: A reset start while a pulse is running reloads it, so `warm_rst` stays 1 for a further `RST_CYCLES` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | ADDR_W | I/O address of the current cycle |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, one clock per write |
| io_rd | input | 1 | I/O read strobe |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | New control word |
| a20m_n | output | 1 | A20 mask, low masks address bit 20 |
| warm_rst | output | 1 | Warm reset pulse, active high |
| p92_rdata | output | 8 | Port 92h read data, 0 when not claimed |
| p92_claim | output | 1 | Port 92h read is decoded by this block |

## Verification
Two sets of events can land in the same cycle. The first is a control-word write together with an I/O write that the new word would enable or disable. The bench provokes this by pulsing `cfg_wr` and `io_wr` on the same edge, and judges the I/O write by the old word. The second is a reset start, from port 92h or from the FEh command, that arrives while a pulse is already running. The bench judges this by the length of the remaining pulse and by the state of `a20m_n` under the override. A behavioural model in the bench computes every output and compares it each clock.

// File: rtl/fast_a20_rst.sv
module fast_a20_rst #(
  parameter int ADDR_W     = 16,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic              a20m_n,
  output logic              warm_rst,
  output logic [7:0]        p92_rdata,
  output logic              p92_claim
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [ADDR_W-1:0] PORT_A  = ADDR_W'(16'h0092);
  localparam logic [ADDR_W-1:0] KBC_CMD = ADDR_W'(16'h0064);
  localparam logic [ADDR_W-1:0] KBC_DAT = ADDR_W'(16'h0060);
  localparam logic [7:0] CMD_WOUT = 8'hD1;
  localparam logic [7:0] CMD_RST  = 8'hFE;
  localparam logic [7:0] CTL_INIT = 8'h98;

  logic [7:0]       ctl;
  logic             a20_en, b0_last, pend;
  logic [CNT_W-1:0] cnt;

  wire snoop_on = ctl[7];
  wire ovr_on   = ctl[4];
  wire dec_on   = ctl[3];

  wire wr_pa  = io_wr && io_addr == PORT_A  && dec_on;
  wire wr_cmd = io_wr && io_addr == KBC_CMD && snoop_on;
  wire wr_dat = io_wr && io_addr == KBC_DAT && snoop_on;

  wire start = (wr_pa && io_wdata[0] && !b0_last) || (wr_cmd && io_wdata == CMD_RST);

  assign warm_rst  = cnt != '0;
  assign a20m_n    = a20_en || (warm_rst && ovr_on);
  assign p92_claim = io_rd && io_addr == PORT_A && dec_on;
  assign p92_rdata = p92_claim ? {6'b0, a20_en, 1'b0} : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= CTL_INIT;
      a20_en  <= 1'b0;
      b0_last <= 1'b0;
      pend    <= 1'b0;
      cnt     <= '0;
    end else begin
      if (cfg_wr) ctl <= cfg_wdata;

      if (wr_pa) begin
        a20_en  <= io_wdata[1];
        b0_last <= io_wdata[0];
      end else if (wr_dat && pend) begin
        a20_en <= io_wdata[1];
      end

      if (!snoop_on)   pend <= 1'b0;
      else if (wr_cmd) pend <= io_wdata == CMD_WOUT;
      else if (wr_dat) pend <= 1'b0;

      if (start)         cnt <= CNT_W'(RST_CYCLES);
      else if (warm_rst) cnt <= cnt - 1'b1;
    end
  end

  a_r3_no_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == PORT_A && !ctl[3]) |=> $stable(a20_en));

  a_r8_snoop_off: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && (io_addr == KBC_DAT || io_addr == KBC_CMD) && !ctl[7]) |=> ($stable(a20_en) && !pend));

  a_r7_fe_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == KBC_CMD && ctl[7] && io_wdata == CMD_RST) |=> warm_rst);

  a_r6_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == KBC_DAT && ctl[7] && pend) |=> (a20_en == $past(io_wdata[1]) && !pend));

  a_r9_override: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_rst && ctl[4]) |-> a20m_n);

  a_r11_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_rst && !start && cnt != CNT_W'(1)) |=> warm_rst);
endmodule

// File: tb/fast_a20_rst_bench.sv
module fast_a20_rst_bench;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [15:0] io_addr = 0;
  logic [7:0] io_wdata = 0, cfg_wdata = 0;
  logic io_wr = 0, io_rd = 0, cfg_wr = 0;
  logic a20m_n, warm_rst, p92_claim;
  logic [7:0] p92_rdata;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  fast_a20_rst #(.ADDR_W(16), .RST_CYCLES(N)) u_fast_a20_rst (
    .clk, .rst_n, .io_addr, .io_wdata, .io_wr, .io_rd, .cfg_wr, .cfg_wdata,
    .a20m_n, .warm_rst, .p92_rdata, .p92_claim);

  int m_ctl, m_a20, m_b0, m_pend, m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = 'h98; m_a20 = 0; m_b0 = 0; m_pend = 0; m_cnt = 0;
    end else begin
      int st, c;
      st = 0; c = m_ctl;
      if (io_wr && io_addr == 'h92 && c[3]) begin
        m_a20 = io_wdata[1];
        if (io_wdata[0] && !m_b0) st = 1;
        m_b0 = io_wdata[0];
      end
      if (io_wr && io_addr == 'h64 && c[7]) begin
        m_pend = (io_wdata == 'hD1);
        if (io_wdata == 'hFE) st = 1;
      end
      if (io_wr && io_addr == 'h60 && c[7] && m_pend) begin
        m_a20 = io_wdata[1]; m_pend = 0;
      end
      if (!c[7]) m_pend = 0;
      m_cnt = st ? N : (m_cnt > 0 ? m_cnt - 1 : 0);
      if (cfg_wr) m_ctl = cfg_wdata;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    int c, mw, cl;
    c = m_ctl; mw = m_cnt > 0;
    cl = io_rd && io_addr == 'h92 && c[3];
    check("R9 a20m_n model", a20m_n, m_a20 | (mw & c[4]));
    check("R4 warm_rst model", warm_rst, mw);
    check("R3 claim model", p92_claim, cl);
    check("R5 rdata model", p92_rdata, cl ? m_a20 << 1 : 0);
  end

  task automatic iow(int a, int d);
    @(posedge clk); #1 io_addr = 16'(a); io_wdata = 8'(d); io_wr = 1;
    @(posedge clk); #1 io_wr = 0;
  endtask
  task automatic cfgw(int d);
    @(posedge clk); #1 cfg_wdata = 8'(d); cfg_wr = 1;
    @(posedge clk); #1 cfg_wr = 0;
  endtask
  task automatic iord(output int data, output int claim);
    @(posedge clk); #1 io_addr = 16'h92; io_rd = 1;
    #2 data = p92_rdata; claim = p92_claim;
    @(posedge clk); #1 io_rd = 0;
  endtask
  task automatic pulse_len(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (warm_rst) n++; else break;
    end
  endtask
  task automatic idle(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  initial begin
    int d, cl, n;
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d, cl, n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 a20m_n after reset", a20m_n, 0);
    check("R1 warm_rst after reset", warm_rst, 0);

    iow('h92, 'h02);
    check("R2 a20 enabled", a20m_n, 1);
    iord(d, cl);
    check("R5 read data", d, 'h02);
    check("R5 claim", cl, 1);

    iow('h92, 'h03);
    pulse_len(n);
    check("R4 pulse length", n, N);
    check("R2 a20 held", a20m_n, 1);
    iow('h92, 'h03);
    idle(1);
    check("R4 no retrigger", warm_rst, 0);
    iord(d, cl);
    check("R5 bit0 reads 0", d, 'h02);

    iow('h92, 'h00);
    check("R2 a20 disabled", a20m_n, 0);
    iow('h92, 'h01);
    check("R9 override high", a20m_n, 1);
    pulse_len(n);
    check("R9 pulse done", n, N);
    check("R9 mask back", a20m_n, 0);

    cfgw('h88);
    iow('h92, 'h00);
    iow('h92, 'h01);
    check("R9 no override", a20m_n, 0);
    check("R9 pulse on", warm_rst, 1);
    idle(3);
    iow('h64, 'hFE);
    pulse_len(n);
    check("R11 restart length", n, N);
    cfgw('h98);

    iow('h64, 'hD1);
    iow('h60, 'h02);
    check("R6 snoop a20 on", a20m_n, 1);
    iow('h64, 'hD1);
    iow('h60, 'h00);
    check("R6 snoop a20 off", a20m_n, 0);
    iow('h64, 'hD1);
    iow('h64, 'hAA);
    iow('h60, 'h02);
    check("R6 pending cancelled", a20m_n, 0);
    iow('h60, 'h02);
    check("R6 pending consumed", a20m_n, 0);

    iow('h64, 'hFE);
    check("R7 FE reset", warm_rst, 1);
    pulse_len(n);
    check("R7 FE length", n, N);

    cfgw('h18);
    iow('h64, 'hD1);
    iow('h60, 'h02);
    check("R8 data ignored", a20m_n, 0);
    iow('h64, 'hFE);
    idle(1);
    check("R8 FE ignored", warm_rst, 0);
    cfgw('h98);
    iow('h60, 'h02);
    check("R8 pending dropped", a20m_n, 0);

    cfgw('h90);
    iow('h92, 'h02);
    check("R3 write ignored", a20m_n, 0);
    iord(d, cl);
    check("R3 no claim", cl, 0);
    check("R3 read zero", d, 0);

    @(posedge clk); #1 cfg_wdata = 8'h98; cfg_wr = 1;
    io_addr = 16'h92; io_wdata = 8'h02; io_wr = 1;
    @(posedge clk); #1 cfg_wr = 0; io_wr = 0;
    check("R10 old control used", a20m_n, 0);
    iow('h92, 'h02);
    check("R10 new control active", a20m_n, 1);

    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule